// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block sits on a twisted-pair receive path and finds out whether the receive wire pair has been connected the wrong way round. A front end that is not part of this block reports two kinds of event: link-integrity pulses and packet starts. Each event carries a flag that says whether its polarity looked reversed. The block keeps a separate run counter for each kind of event. A run of reversed link pulses, or a run of reversed packets, confirms the fault.

Once the fault is confirmed, a status output goes high and stays high until reset. From then on the block inverts the raw receive data itself, so the decoder that follows gets correct data without anyone fixing the cable. Both thresholds are parameters and default to seven link pulses and three packets. The data path is one register deep and has a parameterized width.

Top module: `rxpol_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, `pol_o` is 0 and `rx_data_o` is all zeros.
- R2: A run of LP_THRESH (default 7) consecutive link events with `lp_rev_i`=1 sets `pol_o`. It goes high at the same clock edge that samples the last event of the run.
- R3: A run of PKT_THRESH (default 3) consecutive packet events with `pkt_rev_i`=1 sets `pol_o`. It goes high at the same clock edge that samples the last event of the run.
- R4: Once `pol_o` is 1, it stays 1 whatever the inputs do, until reset clears it.
- R5: `rx_data_o` equals the `rx_data_i` value sampled at the previous clock edge. That value is inverted in every bit if `pol_o` was 1 before that edge, and passed unchanged otherwise.
- R6: A link event with `lp_rev_i`=0 restarts the link run from zero. A cycle with `lp_evt_i`=0 leaves the link run unchanged. The run count saturates at LP_THRESH.
- R7: A packet event with `pkt_rev_i`=0 restarts the packet run from zero. A cycle with `pkt_evt_i`=0 leaves the packet run unchanged. The run count saturates at PKT_THRESH.
- R8: The two runs are independent. Link events never change the packet run, and packet events never change the link run. Either run reaching its threshold sets `pol_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| lp_evt_i | input | 1 | One-cycle strobe: a link pulse was seen |
| lp_rev_i | input | 1 | Link pulse polarity reversed (1) or correct (0) |
| pkt_evt_i | input | 1 | One-cycle strobe: a packet start was seen |
| pkt_rev_i | input | 1 | Packet polarity reversed (1) or correct (0) |
| rx_data_i | input | DATA_W | Raw received data |
| pol_o | output | 1 | Latched reversed-polarity status |
| rx_data_o | output | DATA_W | Registered, polarity-corrected data |

## Verification
There are two timings to check.

- `pol_o` is due one edge after the input cycle that completes a run. The bench drives each event at a falling edge and compares `pol_o` at the next falling edge, against a model that advances once per edge.
- `rx_data_o` is due one edge after its input. It is inverted according to `pol_o` as it stood before that edge. The bench therefore saves the model's polarity before updating it and uses that saved value to predict the data.

The sweeps cover every reversed/correct pattern of twelve link events with idle cycles mixed in, and every pattern of eight packet events with link traffic of opposite polarity interleaved.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_GOOD = 2'd1,
        EV_REV  = 2'd2
    } ev_kind_e;

    function automatic ev_kind_e classify(input logic evt, input logic rev);
        if (!evt) begin
            return EV_NONE;
        end
        return rev ? EV_REV : EV_GOOD;
    endfunction

endpackage

// File: rtl/rxpol_run_counter.sv
module rxpol_run_counter
    import rxpol_pkg::*;
#(
    parameter int THRESH = 7,
    parameter int CNT_W  = $clog2(THRESH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_i,
    input  logic             rev_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             reach_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(THRESH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (classify(evt_i, rev_i))
            EV_GOOD: st_d.cnt = '0;
            EV_REV:  if (st_q.cnt != TOP) st_d.cnt = st_q.cnt + 1'b1;
            default: st_d = st_q;
        endcase
        reach_o = (st_d.cnt == TOP);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/rxpol_latch.sv
module rxpol_latch #(
    parameter int N_SRC = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] set_i,
    output logic             pol_o
);
    typedef struct packed {
        logic pol;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (|set_i) begin
            st_d.pol = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pol_o = st_q.pol;

endmodule

// File: rtl/rxpol_data_path.sv
module rxpol_data_path #(
    parameter int DATA_W = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              inv_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } dp_st_t;

    dp_st_t st_d, st_q;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_comb begin
            st_d.data[b] = data_i[b] ^ inv_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;

endmodule

// File: rtl/rxpol_guard.sv
module rxpol_guard #(
    parameter int LP_THRESH  = 7,
    parameter int PKT_THRESH = 3,
    parameter int DATA_W     = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lp_evt_i,
    input  logic              lp_rev_i,
    input  logic              pkt_evt_i,
    input  logic              pkt_rev_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              pol_o,
    output logic [DATA_W-1:0] rx_data_o
);
    localparam int LP_CW  = $clog2(LP_THRESH + 1);
    localparam int PKT_CW = $clog2(PKT_THRESH + 1);

    logic [LP_CW-1:0]  lp_cnt;
    logic [PKT_CW-1:0] pkt_cnt;
    logic [1:0]        reach;

    rxpol_run_counter #(.THRESH(LP_THRESH), .CNT_W(LP_CW)) u_lp_run (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .evt_i   (lp_evt_i),
        .rev_i   (lp_rev_i),
        .cnt_o   (lp_cnt),
        .reach_o (reach[0])
    );

    rxpol_run_counter #(.THRESH(PKT_THRESH), .CNT_W(PKT_CW)) u_pkt_run (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .evt_i   (pkt_evt_i),
        .rev_i   (pkt_rev_i),
        .cnt_o   (pkt_cnt),
        .reach_o (reach[1])
    );

    rxpol_latch #(.N_SRC(2)) u_latch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (reach),
        .pol_o  (pol_o)
    );

    rxpol_data_path #(.DATA_W(DATA_W)) u_data (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inv_i  (pol_o),
        .data_i (rx_data_i),
        .data_o (rx_data_o)
    );

endmodule

// File: rtl/rxpol_guard_chk.sv
module rxpol_guard_chk #(
    parameter int LP_THRESH  = 7,
    parameter int PKT_THRESH = 3,
    parameter int DATA_W     = 1,
    parameter int LP_CW      = $clog2(LP_THRESH + 1),
    parameter int PKT_CW     = $clog2(PKT_THRESH + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              lp_evt_i,
    input logic              lp_rev_i,
    input logic              pkt_evt_i,
    input logic              pkt_rev_i,
    input logic [DATA_W-1:0] rx_data_i,
    input logic              pol_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic [LP_CW-1:0]  lp_cnt,
    input logic [PKT_CW-1:0] pkt_cnt
);
    localparam logic [LP_CW-1:0]  LP_TOP  = LP_CW'(LP_THRESH);
    localparam logic [PKT_CW-1:0] PKT_TOP = PKT_CW'(PKT_THRESH);

    p_pol_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pol_o |=> pol_o);

    p_lp_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_cnt == LP_TOP) |-> pol_o);

    p_pkt_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_cnt == PKT_TOP) |-> pol_o);

    p_rise_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pol_o) |-> ((lp_cnt == LP_TOP) || (pkt_cnt == PKT_TOP)));

    p_data_fix_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (rx_data_o == ($past(rx_data_i) ^ {DATA_W{$past(pol_o)}})));

    p_lp_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_evt_i && !lp_rev_i) |=> (lp_cnt == '0));

    p_lp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lp_evt_i |=> $stable(lp_cnt));

    p_lp_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_evt_i && lp_rev_i && lp_cnt != LP_TOP) |=> (lp_cnt == $past(lp_cnt) + 1'b1));

    p_pkt_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_evt_i && !pkt_rev_i) |=> (pkt_cnt == '0));

    p_pkt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pkt_evt_i |=> $stable(pkt_cnt));

    p_pkt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_evt_i && pkt_rev_i && pkt_cnt != PKT_TOP) |=> (pkt_cnt == $past(pkt_cnt) + 1'b1));

endmodule

bind rxpol_guard rxpol_guard_chk #(
    .LP_THRESH  (LP_THRESH),
    .PKT_THRESH (PKT_THRESH),
    .DATA_W     (DATA_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lp_evt_i  (lp_evt_i),
    .lp_rev_i  (lp_rev_i),
    .pkt_evt_i (pkt_evt_i),
    .pkt_rev_i (pkt_rev_i),
    .rx_data_i (rx_data_i),
    .pol_o     (pol_o),
    .rx_data_o (rx_data_o),
    .lp_cnt    (lp_cnt),
    .pkt_cnt   (pkt_cnt)
);

// File: tb/rxpol_guard_tb_top.sv
module rxpol_guard_tb_top;
    localparam int LP  = 7;
    localparam int PK  = 3;
    localparam int W   = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lp_evt = 1'b0, lp_rev = 1'b0, pk_evt = 1'b0, pk_rev = 1'b0;
    logic [W-1:0] din = '0;
    logic         pol;
    logic [W-1:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    int m_lp, m_pk;
    bit m_pol;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    rxpol_guard #(.LP_THRESH(LP), .PKT_THRESH(PK), .DATA_W(W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .lp_evt_i(lp_evt), .lp_rev_i(lp_rev),
        .pkt_evt_i(pk_evt), .pkt_rev_i(pk_rev),
        .rx_data_i(din), .pol_o(pol), .rx_data_o(dout)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lp_evt = 0; lp_rev = 0; pk_evt = 0; pk_rev = 0; din = '0;
        @(posedge clk);
        @(negedge clk);
        check("R1 pol in reset", W'(pol), '0);
        check("R1 data in reset", dout, '0);
        din = 4'hF;
        rst_n = 1'b1;
        m_lp = 0; m_pk = 0; m_pol = 0;
        @(posedge clk);
        @(negedge clk);
        check("R1 pol after reset", W'(pol), '0);
        check("R5 data first cycle", dout, 4'hF);
    endtask

    // drive at a falling edge, compare at the next falling edge
    task automatic step(input string tag, input logic le, input logic lr,
                        input logic pe, input logic pr);
        logic [W-1:0] exp_d;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        lp_evt = le; lp_rev = lr; pk_evt = pe; pk_rev = pr; din = lfsr[W-1:0];
        exp_d = lfsr[W-1:0] ^ {W{m_pol}};
        if (le) m_lp = lr ? ((m_lp < LP) ? m_lp + 1 : LP) : 0;
        if (pe) m_pk = pr ? ((m_pk < PK) ? m_pk + 1 : PK) : 0;
        if (m_lp == LP || m_pk == PK) m_pol = 1;
        @(posedge clk);
        @(negedge clk);
        check(tag, W'(pol), W'(m_pol));
        check("R5 data", dout, exp_d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R2 R6: every 12-event link pattern, an idle cycle after every fourth event
        for (int pat = 0; pat < 4096; pat++) begin
            do_reset();
            for (int i = 0; i < 12; i++) begin
                step("R2 R6 link run", 1'b1, pat[i], 1'b0, 1'b0);
                if (i % 4 == 3) step("R6 link idle hold", 1'b0, 1'b0, 1'b0, 1'b0);
            end
        end
        // R3 R7 R8: every 8-packet pattern, link events of opposite polarity alongside
        for (int pat = 0; pat < 256; pat++) begin
            do_reset();
            for (int i = 0; i < 8; i++) begin
                step("R3 R7 R8 packet run", 1'b1, ~pat[i], 1'b1, pat[i]);
                if (i % 3 == 2) step("R7 packet idle hold", 1'b0, 1'b0, 1'b0, 1'b0);
            end
        end
        // R4: latch holds under correct traffic, reset clears it
        do_reset();
        for (int i = 0; i < PK; i++) step("R3 set", 1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 20; i++) step("R4 latched", 1'b1, 1'b0, 1'b1, 1'b0);
        check("R4 still set", W'(pol), W'(1));
        do_reset();
        check("R4 cleared by reset", W'(pol), '0);
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule